// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Aggregator

This block gathers interrupt requests for one peripheral and presents them to software through a small 32-bit register window. Hardware event pulses land in a latched source-status register. Each bit of that register can be cleared or forced by toggle-on-write, and it is qualified by a per-source enable mask. The OR of the qualified sources becomes one bit of a device-level status register. A second bit of that register holds a latched internal error condition.

The device-level status is qualified by its own enable mask to form a live pending vector. A priority resolver turns that vector into the index of the lowest-numbered pending bit, or into a reserved "nothing pending" code. A master enable bit gates the single registered interrupt line. Software can use this bit to mask the device around a critical section without touching either enable mask.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous reset, every status, enable and master-enable register reads 0, the ID register (0x0C) reads 128 and `irq_out` is 0.
- R2: A 1 on bit i of `hw_evt` sets bit i of the source-status register (0x20) at the next clock edge, whatever the enable settings are.
- R3: A write to the source-status register inverts each bit whose write-data bit is 1 and leaves every other bit unchanged.
- R4: If a hardware event and a toggle write hit the same source-status bit in the same cycle, the bit is 1 afterwards.
- R5: Device status (0x00) bit 1 reads as the OR over all sources of (source status AND source enable at 0x28), with no added delay.
- R6: `err_evt` sets device status bit 0, which stays set. Writing 1 to bit 0 of 0x00 clears it, and writing 0 has no effect.
- R7: The pending register (0x08) reads as device status AND device enable (0x04). Bits 1:0 are implemented.
- R8: The ID register reads the index of the lowest-numbered set pending bit, so the error (bit 0) has ID 0 and the source aggregate (bit 1) has ID 1. With nothing pending it reads 128.
- R9: `irq_out` equals (master enable AND any pending bit) as it stood one clock earlier.
- R10: The master enable is bit 31 of 0x1C. Writing it leaves 0x04 and 0x28 unchanged.
- R11: Writes to 0x08 and 0x0C have no effect, and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_evt | input | IP_SRC | Per-source hardware event pulses |
| err_evt | input | 1 | Internal error condition pulse |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The assertions assume that a bus write lasts exactly one cycle and that `bus_addr` and `bus_we` are held stable across the clock edge. They also assume that the event inputs are synchronous pulses. The bench meets these assumptions by driving every input on the falling edge and releasing the write strobe one cycle later. The set-versus-toggle assertion assumes that a source never sees a toggle write to 0x20 in a cycle where it is meant to clear while its event line is still high. The stimulus pairs the two only in the deliberate same-cycle collision test.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;
    localparam int ID_W   = 8;
    localparam int DEV_W  = 2;

    localparam logic [ID_W-1:0] NONE_ID = 8'd128;

    localparam int ERR_BIT    = 0;
    localparam int SRC_BIT    = 1;
    localparam int MASTER_BIT = 31;

    localparam logic [ADDR_W-1:0] OFS_DSTAT  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_DEN    = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_DPEND  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_ID     = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_MASTER = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_SSTAT  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_SEN    = 8'h28;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DSTAT,
        SEL_DEN,
        SEL_DPEND,
        SEL_ID,
        SEL_MASTER,
        SEL_SSTAT,
        SEL_SEN
    } reg_sel_e;

    typedef struct packed {
        logic               we;
        reg_sel_e           sel;
        logic [BUS_W-1:0]   wdata;
    } bus_req_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_DSTAT:  return SEL_DSTAT;
            OFS_DEN:    return SEL_DEN;
            OFS_DPEND:  return SEL_DPEND;
            OFS_ID:     return SEL_ID;
            OFS_MASTER: return SEL_MASTER;
            OFS_SSTAT:  return SEL_SSTAT;
            OFS_SEN:    return SEL_SEN;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic is_write(input bus_req_t r, input reg_sel_e s);
        return r.we && (r.sel == s);
    endfunction

endpackage

// File: rtl/irq_src_level.sv
module irq_src_level
    import irq_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hw_evt,
    input  logic         wr_stat,
    input  logic         wr_en,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] stat,
    output logic [N-1:0] en,
    output logic         any_req
);

    logic [N-1:0] toggle_mask;
    logic [N-1:0] stat_nxt;

    always_comb begin
        toggle_mask = wr_stat ? wdata : '0;
        stat_nxt    = (stat ^ toggle_mask) | hw_evt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            en   <= '0;
        end else begin
            stat <= stat_nxt;
            if (wr_en) en <= wdata;
        end
    end

    assign any_req = |(stat & en);

    assert_evt_latched_R4: assert property (@(posedge clk) disable iff (rst)
        (|hw_evt) |=> ((stat & $past(hw_evt)) == $past(hw_evt)));

    assert_stat_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!wr_stat && (hw_evt == '0)) |=> $stable(stat));

    assert_en_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(en));

endmodule

// File: rtl/irq_dev_level.sv
module irq_dev_level
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             err_evt,
    input  logic             src_req,
    input  logic             wr_stat,
    input  logic             wr_en,
    input  logic [DEV_W-1:0] wdata,
    output logic [DEV_W-1:0] stat,
    output logic [DEV_W-1:0] en,
    output logic [DEV_W-1:0] pend
);

    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
            en    <= '0;
        end else begin
            if (err_evt)
                err_q <= 1'b1;
            else if (wr_stat && wdata[ERR_BIT])
                err_q <= 1'b0;
            if (wr_en) en <= wdata;
        end
    end

    always_comb begin
        stat          = '0;
        stat[ERR_BIT] = err_q;
        stat[SRC_BIT] = src_req;
    end

    assign pend = stat & en;

    assert_err_set_R6: assert property (@(posedge clk) disable iff (rst)
        err_evt |=> stat[ERR_BIT]);

    assert_err_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wdata[ERR_BIT] && !err_evt) |=> !stat[ERR_BIT]);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (stat[ERR_BIT] && !(wr_stat && wdata[ERR_BIT])) |=> stat[ERR_BIT]);

endmodule

// File: rtl/irq_prio.sv
module irq_prio
    import irq_pkg::*;
#(
    parameter int N = DEV_W
) (
    input  logic [N-1:0]    pend,
    output logic [ID_W-1:0] id
);

    always_comb begin
        id = NONE_ID;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) id = ID_W'(i);
        end
    end

    always_comb begin
        assert_none_code_R8: assert ((id == NONE_ID) == (pend == '0));
        if (id != NONE_ID) begin
            assert_id_hit_R8: assert (pend[id[$clog2(N+1)-1:0]]);
        end
    end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_pkg::*;
#(
    parameter int IP_SRC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IP_SRC-1:0] hw_evt,
    input  logic              err_evt,
    input  logic [7:0]        bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_out
);

    bus_req_t           req;
    logic [IP_SRC-1:0]  src_stat;
    logic [IP_SRC-1:0]  src_en;
    logic               src_any;
    logic [DEV_W-1:0]   dev_stat;
    logic [DEV_W-1:0]   dev_en;
    logic [DEV_W-1:0]   dev_pend;
    logic [ID_W-1:0]    top_id;
    logic               master_q;
    logic               irq_q;

    always_comb begin
        req.we    = bus_we;
        req.sel   = decode_ofs(bus_addr);
        req.wdata = bus_wdata;
    end

    irq_src_level #(.N(IP_SRC)) u_src (
        .clk     (clk),
        .rst     (rst),
        .hw_evt  (hw_evt),
        .wr_stat (is_write(req, SEL_SSTAT)),
        .wr_en   (is_write(req, SEL_SEN)),
        .wdata   (req.wdata[IP_SRC-1:0]),
        .stat    (src_stat),
        .en      (src_en),
        .any_req (src_any)
    );

    irq_dev_level u_dev (
        .clk     (clk),
        .rst     (rst),
        .err_evt (err_evt),
        .src_req (src_any),
        .wr_stat (is_write(req, SEL_DSTAT)),
        .wr_en   (is_write(req, SEL_DEN)),
        .wdata   (req.wdata[DEV_W-1:0]),
        .stat    (dev_stat),
        .en      (dev_en),
        .pend    (dev_pend)
    );

    irq_prio #(.N(DEV_W)) u_prio (
        .pend (dev_pend),
        .id   (top_id)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            master_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (is_write(req, SEL_MASTER)) master_q <= req.wdata[MASTER_BIT];
            irq_q <= master_q && (|dev_pend);
        end
    end

    assign irq_out = irq_q;

    always_comb begin
        bus_rdata = '0;
        case (req.sel)
            SEL_DSTAT:  bus_rdata = BUS_W'(dev_stat);
            SEL_DEN:    bus_rdata = BUS_W'(dev_en);
            SEL_DPEND:  bus_rdata = BUS_W'(dev_pend);
            SEL_ID:     bus_rdata = BUS_W'(top_id);
            SEL_MASTER: bus_rdata[MASTER_BIT] = master_q;
            SEL_SSTAT:  bus_rdata = BUS_W'(src_stat);
            SEL_SEN:    bus_rdata = BUS_W'(src_en);
            default:    bus_rdata = '0;
        endcase
    end

    assert_irq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> $past(master_q && (dev_pend != '0)));

    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (rst)
        (master_q && (dev_pend != '0)) |=> irq_out);

    assert_master_keeps_en_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == OFS_MASTER)) |=> ($stable(dev_en) && $stable(src_en)));

    assert_ro_pend_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_we && (bus_addr == OFS_DPEND) && !err_evt && (hw_evt == '0)) |=> $stable(dev_stat));

endmodule

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  hw_evt;
    logic        err_evt;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    irq_aggregator #(.IP_SRC(8)) i_irq_aggregator (
        .clk, .rst, .hw_evt, .err_evt, .bus_addr, .bus_we,
        .bus_wdata, .bus_rdata, .irq_out
    );

    // kind: 0 write, 1 read-compare, 2 hardware event pulse, 3 error pulse
    typedef struct packed {
        logic [1:0]  kind;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t TBL [NV] = '{
        '{2'd2, 8'h00, 32'h05, 32'h0, 4'd2},        // R2 events with enables off
        '{2'd1, 8'h20, 32'h0,  32'h05, 4'd2},       // R2 latched
        '{2'd1, 8'h00, 32'h0,  32'h0, 4'd5},        // R5 no source enabled
        '{2'd1, 8'h0C, 32'h0,  32'd128, 4'd8},      // R8 none pending
        '{2'd0, 8'h28, 32'h04, 32'h0, 4'd5},
        '{2'd1, 8'h00, 32'h0,  32'h2, 4'd5},        // R5 aggregate up
        '{2'd1, 8'h08, 32'h0,  32'h0, 4'd7},        // R7 device enable off
        '{2'd0, 8'h04, 32'h2,  32'h0, 4'd7},
        '{2'd1, 8'h08, 32'h0,  32'h2, 4'd7},        // R7
        '{2'd1, 8'h0C, 32'h0,  32'd1, 4'd8},        // R8 id 1
        '{2'd3, 8'h00, 32'h0,  32'h0, 4'd6},
        '{2'd1, 8'h00, 32'h0,  32'h3, 4'd6},        // R6 error latched
        '{2'd1, 8'h08, 32'h0,  32'h2, 4'd7},        // R7 bit0 masked
        '{2'd0, 8'h04, 32'h3,  32'h0, 4'd7},
        '{2'd1, 8'h08, 32'h0,  32'h3, 4'd7},        // R7
        '{2'd1, 8'h0C, 32'h0,  32'd0, 4'd8},        // R8 error wins
        '{2'd0, 8'h00, 32'h0,  32'h0, 4'd6},
        '{2'd1, 8'h00, 32'h0,  32'h3, 4'd6},        // R6 write 0 no effect
        '{2'd0, 8'h00, 32'h1,  32'h0, 4'd6},
        '{2'd1, 8'h00, 32'h0,  32'h2, 4'd6},        // R6 cleared
        '{2'd1, 8'h0C, 32'h0,  32'd1, 4'd8},        // R8
        '{2'd0, 8'h20, 32'h05, 32'h0, 4'd3},
        '{2'd1, 8'h20, 32'h0,  32'h0, 4'd3},        // R3 toggle clears
        '{2'd1, 8'h0C, 32'h0,  32'd128, 4'd8},      // R8 none again
        '{2'd0, 8'h20, 32'h84, 32'h0, 4'd3},
        '{2'd1, 8'h20, 32'h0,  32'h84, 4'd3},       // R3 toggle forces
        '{2'd1, 8'h00, 32'h0,  32'h2, 4'd5},        // R5
        '{2'd0, 8'h08, 32'hFF, 32'h0, 4'd11},
        '{2'd1, 8'h08, 32'h0,  32'h2, 4'd11},       // R11 read-only pending
        '{2'd1, 8'h10, 32'h0,  32'h0, 4'd11}        // R11 unmapped
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        #0.5;
        check(tag, bus_rdata, exp);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        rst = 1'b1; hw_evt = '0; err_evt = 1'b0;
        bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h00, 32'h0, "R1 dstat");
        rd(8'h1C, 32'h0, "R1 master");
        rd(8'h0C, 32'd128, "R1 id");
        check("R1 irq", 32'(irq_out), 32'h0);

        for (int k = 0; k < NV; k++) begin
            case (TBL[k].kind)
                2'd0: wr(TBL[k].addr, TBL[k].data);
                2'd1: begin
                    @(negedge clk);
                    bus_addr = TBL[k].addr; bus_we = 1'b0;
                    #0.5;
                    n_chk++;
                    if (bus_rdata !== TBL[k].exp) begin
                        n_fail++;
                        $display("FAIL R%0d vector %0d actual=%0h expected=%0h",
                                 TBL[k].req, k, bus_rdata, TBL[k].exp);
                    end
                end
                2'd2: begin
                    @(negedge clk); hw_evt = TBL[k].data[7:0];
                    @(negedge clk); hw_evt = '0;
                end
                default: begin
                    @(negedge clk); err_evt = 1'b1;
                    @(negedge clk); err_evt = 1'b0;
                end
            endcase
        end

        // R9: pending set, master off -> no irq
        check("R9 irq masked", 32'(irq_out), 32'h0);
        // R10 master on; irq one cycle after the master bit
        wr(8'h1C, 32'h8000_0000);
        check("R9 irq latency", 32'(irq_out), 32'h0);
        @(negedge clk);
        check("R9 irq up", 32'(irq_out), 32'h1);
        rd(8'h1C, 32'h8000_0000, "R10 master read");
        rd(8'h04, 32'h3, "R10 dev en kept");
        rd(8'h28, 32'h04, "R10 src en kept");
        wr(8'h1C, 32'h0);
        check("R9 irq lag", 32'(irq_out), 32'h1);
        @(negedge clk);
        check("R9 irq down", 32'(irq_out), 32'h0);
        rd(8'h04, 32'h3, "R10 dev en after off");
        rd(8'h28, 32'h04, "R10 src en after off");

        // R4 collision: bit2 is 1, toggle and event same cycle
        @(negedge clk);
        bus_addr = 8'h20; bus_wdata = 32'h04; bus_we = 1'b1; hw_evt = 8'h04;
        @(negedge clk);
        bus_we = 1'b0; hw_evt = '0;
        rd(8'h20, 32'h84, "R4 set wins");

        // R11 write to ID ignored
        wr(8'h0C, 32'h0);
        rd(8'h0C, 32'd1, "R11 id read-only");

        // R1 mid-run reset
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(8'h20, 32'h0, "R1 sstat");
        rd(8'h28, 32'h0, "R1 sen");
        rd(8'h04, 32'h0, "R1 den");
        rd(8'h0C, 32'd128, "R1 id after");
        check("R1 irq after", 32'(irq_out), 32'h0);

        done = 1;
        summary();
    end

endmodule